// File: doc/BRIEF.md
# Interrupt Request Priority Controller

This block is the receive and arbitration side of a per-core interrupt controller. Delivery messages arrive on a valid/ready port. Each message carries an 8-bit vector, a destination, a destination-mode flag, a 3-bit delivery mode and a trigger-mode flag. Messages addressed to this core with a maskable delivery mode are queued in a 256-entry request array. The trigger kind of each newly queued vector is recorded in a parallel trigger array.

A priority encoder keeps a registered copy of the highest requested vector. The block asserts a pending output when three conditions hold together:
- that vector outranks the vector currently in service;
- the core's interrupt-enable input is high;
- the vector's priority class (its upper nibble) is above the class held in the task-priority register.

The core takes the offered vector with an acknowledge pulse. The vector then moves from the request array to the in-service array. An end-of-interrupt pulse retires the current in-service vector, and the next-highest in-service vector becomes current.

The message port never applies back-pressure outside reset. `msg_ready` is high in every cycle that reset is low, and a message is consumed in any cycle where `msg_valid` and `msg_ready` are both high. The sender must hold the message fields stable while `msg_valid` is high and `msg_ready` is low, which happens only during reset. Messages addressed elsewhere, or carrying an unused delivery mode, are consumed and dropped.

Top module: `irq_prio_ctrl`

## Requirements
- R1: `msg_ready` is 0 while `rst` is high and 1 otherwise. A message is consumed on every clock edge where `msg_valid` and `msg_ready` are both 1.
- R2: A consumed message is addressed to this core only in one of two cases. With `msg_dest_logical`=0, `msg_dest` must equal `local_id`. With `msg_dest_logical`=1, `msg_dest` AND `local_id` must be non-zero. Unaddressed messages change no state and raise no error.
- R3: Delivery modes 0, 1 and 7 are maskable. An addressed maskable message whose vector has no request bit set sets that bit. It also sets the vector's trigger bit when `msg_level`=1 and clears it when `msg_level`=0. If the request bit is already set, neither array changes.
- R4: Delivery modes 2, 4, 5 and 6 are unmaskable. An addressed unmaskable message changes no array and pulses `err_unmaskable` high for exactly the cycle after it is consumed. Mode 3 is dropped without an error.
- R5: `irq_vector` is the highest set request bit, updated one clock after any change to the request array, and is 0 when no request bit is set.
- R6: `irq_pending` is 1 exactly when all three of these hold: `irq_vector` > `in_service_vector`, `int_enable`=1, and `irq_vector[7:4]` > `tpr_q[7:4]`.
- R7: When `tpr_we`=1 at a clock edge, `tpr_q` takes `tpr_wdata` on that edge.
- R8: An `irq_ack` with `irq_pending`=1 does three things on that edge: it copies `irq_vector` into `in_service_vector`, sets that vector's in-service bit, and clears its request bit. An `irq_ack` while `irq_pending`=0 has no effect.
- R9: An `eoi` pulse clears the in-service bit of `in_service_vector`. `in_service_vector` then becomes the highest remaining in-service bit, or 0 if none remain. An accepted acknowledge in the same cycle takes precedence, and that `eoi` is ignored.
- R10: `irq_level` shows the trigger bit recorded for `irq_vector`: 1 for level, 0 for edge.
- R11: A synchronous active-high `rst` clears all three arrays, `irq_vector`, `in_service_vector`, `tpr_q` and `err_unmaskable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| msg_valid | input | 1 | Message offered |
| msg_ready | output | 1 | Message can be consumed |
| msg_vector | input | 8 | Interrupt vector |
| msg_dest | input | 8 | Destination ID or ID mask |
| msg_dest_logical | input | 1 | 0 = exact ID match, 1 = mask match |
| msg_dlv_mode | input | 3 | Delivery mode |
| msg_level | input | 1 | 1 = level trigger, 0 = edge trigger |
| local_id | input | 8 | This core's ID |
| int_enable | input | 1 | Core interrupt enable |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 8 | Task-priority write data |
| tpr_q | output | 8 | Task-priority register |
| irq_pending | output | 1 | Interrupt offered to the core |
| irq_vector | output | 8 | Highest pending vector |
| irq_level | output | 1 | Trigger kind of `irq_vector` |
| irq_ack | input | 1 | Core takes the offered vector |
| eoi | input | 1 | Retire the current in-service vector |
| in_service_vector | output | 8 | Current in-service vector |
| err_unmaskable | output | 1 | One-cycle flag for a rejected unmaskable message |

## Verification
The message table drives the main function through a set of messages that build up state one after another:
- Some vectors raise the maximum and some sit below it, which separates a true maximum from a last-written register.
- Exact and mask destinations, each with a matching and a non-matching ID, show whether the address filter is applied.
- Maskable, unmaskable and unused delivery modes show whether the mode classification is correct.
- A repeated vector with the opposite trigger flag shows whether the trigger bit is wrongly overwritten.

Directed sequences follow. They cover:
- task-priority values whose class is equal to, or just below, the pending class;
- an acknowledge while nothing is pending;
- nested in-service vectors retired one by one;
- an acknowledge and an end-of-interrupt in the same cycle;
- a reset in the middle of a run.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  typedef enum logic [2:0] {
    DLV_FIXED    = 3'd0,
    DLV_LOWEST   = 3'd1,
    DLV_SMI      = 3'd2,
    DLV_RSVD     = 3'd3,
    DLV_NMI      = 3'd4,
    DLV_INIT     = 3'd5,
    DLV_STARTUP  = 3'd6,
    DLV_EXTINT   = 3'd7
  } dlv_mode_e;

  function automatic logic dlv_is_maskable(input logic [2:0] m);
    return (m == DLV_FIXED) || (m == DLV_LOWEST) || (m == DLV_EXTINT);
  endfunction

  function automatic logic dlv_is_unmaskable(input logic [2:0] m);
    return (m == DLV_SMI) || (m == DLV_NMI) || (m == DLV_INIT) ||
           (m == DLV_STARTUP);
  endfunction

endpackage

// File: rtl/irq_msg_filter.sv
module irq_msg_filter #(
  parameter int ID_W = 8
) (
  input  logic [ID_W-1:0] dest,
  input  logic            dest_logical,
  input  logic [ID_W-1:0] local_id,
  input  logic [2:0]      dlv_mode,
  output logic            take_maskable,
  output logic            take_unmaskable
);
  import irq_prio_pkg::*;

  logic addressed;

  always_comb begin
    if (dest_logical) addressed = |(dest & local_id);
    else              addressed = (dest == local_id);
    take_maskable   = addressed && dlv_is_maskable(dlv_mode);
    take_unmaskable = addressed && dlv_is_unmaskable(dlv_mode);
  end

endmodule

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder #(
  parameter int N     = 256,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     bits_in,
  output logic [IDX_W-1:0] top_idx,
  output logic             any_set
);

  always_comb begin
    top_idx = '0;
    any_set = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (bits_in[i]) begin
        top_idx = IDX_W'(i);
        any_set = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_service_track.sv
module irq_service_track #(
  parameter int VEC_W = 8,
  localparam int NVEC = 1 << VEC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [VEC_W-1:0] take_vec,
  input  logic             retire,
  output logic [VEC_W-1:0] cur_vec
);

  logic [NVEC-1:0]  isr_q, isr_d, isr_rest;
  logic [VEC_W-1:0] cur_d, next_idx;
  logic             next_any;

  always_comb begin
    isr_rest          = isr_q;
    isr_rest[cur_vec] = 1'b0;
  end

  irq_prio_encoder #(.N(NVEC), .IDX_W(VEC_W)) u_next_enc (
    .bits_in (isr_rest),
    .top_idx (next_idx),
    .any_set (next_any)
  );

  always_comb begin
    isr_d = isr_q;
    cur_d = cur_vec;
    if (take) begin
      isr_d[take_vec] = 1'b1;
      cur_d           = take_vec;
    end else if (retire) begin
      isr_d = isr_rest;
      cur_d = next_any ? next_idx : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q   <= '0;
      cur_vec <= '0;
    end else begin
      isr_q   <= isr_d;
      cur_vec <= cur_d;
    end
  end

  assert_cur_marked_R9: assert property (@(posedge clk) disable iff (rst)
    (cur_vec != '0) |-> isr_q[cur_vec]);

  assert_take_marks_R8: assert property (@(posedge clk) disable iff (rst)
    take |=> (isr_q[$past(take_vec)] && cur_vec == $past(take_vec)));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int VEC_W = 8,
  parameter int ID_W  = 8,
  parameter int CLS_W = 4,
  localparam int NVEC = 1 << VEC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             msg_valid,
  output logic             msg_ready,
  input  logic [VEC_W-1:0] msg_vector,
  input  logic [ID_W-1:0]  msg_dest,
  input  logic             msg_dest_logical,
  input  logic [2:0]       msg_dlv_mode,
  input  logic             msg_level,
  input  logic [ID_W-1:0]  local_id,
  input  logic             int_enable,
  input  logic             tpr_we,
  input  logic [VEC_W-1:0] tpr_wdata,
  output logic [VEC_W-1:0] tpr_q,
  output logic             irq_pending,
  output logic [VEC_W-1:0] irq_vector,
  output logic             irq_level,
  input  logic             irq_ack,
  input  logic             eoi,
  output logic [VEC_W-1:0] in_service_vector,
  output logic             err_unmaskable
);

  logic [NVEC-1:0]  req_q, req_d, trig_q, trig_d;
  logic [VEC_W-1:0] enc_idx;
  logic             enc_any;
  logic             take_mask, take_nmi, msg_fire, set_new, ack_fire;

  assign msg_ready = ~rst;
  assign msg_fire  = msg_valid & msg_ready;

  irq_msg_filter #(.ID_W(ID_W)) u_filter (
    .dest            (msg_dest),
    .dest_logical    (msg_dest_logical),
    .local_id        (local_id),
    .dlv_mode        (msg_dlv_mode),
    .take_maskable   (take_mask),
    .take_unmaskable (take_nmi)
  );

  assign set_new = msg_fire && take_mask && !req_q[msg_vector];

  always_comb begin
    irq_pending = (irq_vector > in_service_vector) && int_enable &&
                  (irq_vector[VEC_W-1 -: CLS_W] > tpr_q[VEC_W-1 -: CLS_W]);
    ack_fire    = irq_ack && irq_pending;
  end

  always_comb begin
    req_d  = req_q;
    trig_d = trig_q;
    if (set_new) begin
      req_d[msg_vector]  = 1'b1;
      trig_d[msg_vector] = msg_level;
    end
    if (ack_fire) req_d[irq_vector] = 1'b0;
  end

  irq_prio_encoder #(.N(NVEC), .IDX_W(VEC_W)) u_req_enc (
    .bits_in (req_q),
    .top_idx (enc_idx),
    .any_set (enc_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q          <= '0;
      trig_q         <= '0;
      irq_vector     <= '0;
      tpr_q          <= '0;
      err_unmaskable <= 1'b0;
    end else begin
      req_q          <= req_d;
      trig_q         <= trig_d;
      irq_vector     <= enc_any ? enc_idx : '0;
      err_unmaskable <= msg_fire && take_nmi;
      if (tpr_we) tpr_q <= tpr_wdata;
    end
  end

  assign irq_level = trig_q[irq_vector];

  irq_service_track #(.VEC_W(VEC_W)) u_service (
    .clk      (clk),
    .rst      (rst),
    .take     (ack_fire),
    .take_vec (irq_vector),
    .retire   (eoi),
    .cur_vec  (in_service_vector)
  );

  assert_new_req_set_R3: assert property (@(posedge clk) disable iff (rst)
    set_new |=> req_q[$past(msg_vector)]);

  assert_err_follows_msg_R4: assert property (@(posedge clk) disable iff (rst)
    err_unmaskable |-> $past(msg_valid && msg_ready));

  assert_nmi_flags_R4: assert property (@(posedge clk) disable iff (rst)
    (msg_fire && take_nmi) |=> err_unmaskable);

  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(req_q) == '0) |-> (irq_vector == '0));

  assert_ack_moves_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_pending) |=> (in_service_vector == $past(irq_vector)));

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_pending && !(msg_fire && msg_vector == irq_vector)) |=>
      !req_q[$past(irq_vector)]);

  assert_pend_needs_ie_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_pending) |-> int_enable);

endmodule

// File: tb/irq_prio_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic msg_valid = 1'b0, msg_dest_logical = 1'b0, msg_level = 1'b0;
  logic [7:0] msg_vector = '0, msg_dest = '0, local_id = 8'h05;
  logic [2:0] msg_dlv_mode = '0;
  logic int_enable = 1'b1, tpr_we = 1'b0, irq_ack = 1'b0, eoi = 1'b0;
  logic [7:0] tpr_wdata = '0;
  logic msg_ready, irq_pending, irq_level, err_unmaskable;
  logic [7:0] tpr_q, irq_vector, in_service_vector;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic err_seen;

  always #2 clk = ~clk;

  irq_prio_ctrl dut_i (
    .clk(clk), .rst(rst), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_vector(msg_vector), .msg_dest(msg_dest),
    .msg_dest_logical(msg_dest_logical), .msg_dlv_mode(msg_dlv_mode),
    .msg_level(msg_level), .local_id(local_id), .int_enable(int_enable),
    .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .tpr_q(tpr_q),
    .irq_pending(irq_pending), .irq_vector(irq_vector), .irq_level(irq_level),
    .irq_ack(irq_ack), .eoi(eoi), .in_service_vector(in_service_vector),
    .err_unmaskable(err_unmaskable)
  );

  // row: vec, dest, logical, mode, level | exp vector, exp pending, exp level, exp err
  localparam logic [31:0] TBL [9] = '{
    {8'h30, 8'h05, 1'b0, 3'd0, 1'b0, 8'h30, 1'b1, 1'b0, 1'b0},
    {8'h20, 8'h05, 1'b0, 3'd0, 1'b1, 8'h30, 1'b1, 1'b0, 1'b0},
    {8'h80, 8'h04, 1'b0, 3'd0, 1'b1, 8'h30, 1'b1, 1'b0, 1'b0},
    {8'h80, 8'h04, 1'b1, 3'd1, 1'b1, 8'h80, 1'b1, 1'b1, 1'b0},
    {8'h90, 8'h0A, 1'b1, 3'd0, 1'b0, 8'h80, 1'b1, 1'b1, 1'b0},
    {8'hA0, 8'h05, 1'b0, 3'd4, 1'b0, 8'h80, 1'b1, 1'b1, 1'b1},
    {8'hA0, 8'h05, 1'b0, 3'd3, 1'b0, 8'h80, 1'b1, 1'b1, 1'b0},
    {8'hB0, 8'h05, 1'b0, 3'd7, 1'b0, 8'hB0, 1'b1, 1'b0, 1'b0},
    {8'hB0, 8'h05, 1'b0, 3'd0, 1'b1, 8'hB0, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] v, input logic [7:0] d, input logic lg,
                      input logic [2:0] m, input logic lv);
    msg_vector = v; msg_dest = d; msg_dest_logical = lg;
    msg_dlv_mode = m; msg_level = lv; msg_valid = 1'b1;
    @(negedge clk);
    err_seen = err_unmaskable;
    msg_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_ack_eoi(input logic a, input logic e);
    irq_ack = a; eoi = e;
    @(negedge clk);
    irq_ack = 1'b0; eoi = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_tpr(input logic [7:0] v);
    tpr_wdata = v; tpr_we = 1'b1;
    @(negedge clk);
    tpr_we = 1'b0;
  endtask

  task automatic report;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 ready low in reset", msg_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset vector", irq_vector, 8'h00);
    chk("R11 reset in-service", in_service_vector, 8'h00);
    chk("R11 reset pending", irq_pending, 0);
    chk("R11 reset tpr", tpr_q, 0);
    chk("R1 ready after reset", msg_ready, 1);

    for (int i = 0; i < 9; i++) begin
      send(TBL[i][31:24], TBL[i][23:16], TBL[i][15], TBL[i][14:12], TBL[i][11]);
      chk("R4 error pulse", err_seen, TBL[i][0]);
      chk("R5 highest vector (R2 R3)", irq_vector, TBL[i][10:3]);
      chk("R6 pending", irq_pending, TBL[i][2]);
      chk("R10 trigger kind", irq_level, TBL[i][1]);
    end

    write_tpr(8'hB0);
    chk("R7 tpr write", tpr_q, 8'hB0);
    chk("R6 equal class blocks", irq_pending, 0);
    write_tpr(8'hA5);
    chk("R6 lower class passes", irq_pending, 1);
    write_tpr(8'h00);
    int_enable = 1'b0; #1;
    chk("R6 enable low", irq_pending, 0);
    int_enable = 1'b1; #1;

    pulse_ack_eoi(1, 0);
    chk("R8 ack in-service", in_service_vector, 8'hB0);
    chk("R8 request cleared", irq_vector, 8'h80);
    chk("R6 below in-service", irq_pending, 0);
    chk("R10 level of 80", irq_level, 1);
    pulse_ack_eoi(1, 0);
    chk("R8 ack ignored in-service", in_service_vector, 8'hB0);
    chk("R8 ack ignored vector", irq_vector, 8'h80);
    pulse_ack_eoi(0, 1);
    chk("R9 eoi empties", in_service_vector, 8'h00);
    chk("R6 pending after eoi", irq_pending, 1);
    pulse_ack_eoi(1, 0);
    chk("R8 ack 80", in_service_vector, 8'h80);
    chk("R8 next vector", irq_vector, 8'h30);
    send(8'h90, 8'h05, 0, 3'd0, 1);
    chk("R6 nested pending", irq_pending, 1);
    chk("R10 level of 90", irq_level, 1);
    pulse_ack_eoi(1, 0);
    chk("R8 ack 90", in_service_vector, 8'h90);
    pulse_ack_eoi(0, 1);
    chk("R9 next highest", in_service_vector, 8'h80);
    pulse_ack_eoi(0, 1);
    chk("R9 last retired", in_service_vector, 8'h00);
    pulse_ack_eoi(1, 1);
    chk("R9 ack wins over eoi", in_service_vector, 8'h30);
    chk("R8 vector after 30", irq_vector, 8'h20);
    chk("R10 level of 20", irq_level, 1);

    rst = 1'b1;
    @(negedge clk);
    chk("R1 ready low in reset", msg_ready, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 mid reset vector", irq_vector, 8'h00);
    chk("R11 mid reset in-service", in_service_vector, 8'h00);
    chk("R11 mid reset pending", irq_pending, 0);
    send(8'h40, 8'h05, 0, 3'd0, 0);
    chk("R11 arrays clear after reset", irq_vector, 8'h40);
    chk("R10 edge of 40", irq_level, 0);

    done = 1;
    report();
  end

endmodule